// File: doc/BRIEF.md
# Byte-Channel to Word Bus Bridge

This block lets a byte-serial data channel drive a 32-bit word read/write bus with 16-bit addresses. The bus uses a request and acknowledge handshake. After a start pulse the bridge walks a list held in channel memory. The channel side is an abstract byte port: the bridge raises a request, either to fetch the next byte of the list or to store one byte back into it, and the channel answers each request with a one-cycle acknowledge.

A list begins with an order byte, which the bridge discards. The bridge then writes one status byte carrying the outcome of the last operation of the previous list. After that come operations, one after another. Each operation has a control byte, two address bytes and, for a write, four data bytes. Reads place their four returned data bytes back into the list. Every operation except the last one writes its own status byte. The status of the last operation is held inside the bridge and appears at the head of the next list. If the word bus does not acknowledge in time, a sticky rate-error flag is set and the list is abandoned.

Top module: `byte_dio_bridge`

## Requirements
- R1: After reset, busy, done, rate_err, ch_req and dio_req are all low. While the bridge is idle, neither ch_req nor dio_req is raised.
- R2: The first byte fetched after start is an order byte. It is discarded whatever its value and does not produce a done pulse.
- R3: The first byte written in every list is the status byte {4'b0000, S[1:0], 2'b00}, where S is the status of the last acknowledged operation of an earlier list. S is 2'b00 after reset.
- R4: Each operation begins with a control byte. Bit 0 set means a read and bit 0 clear means a write. Bit 7 set marks the last operation of the list. The control byte is followed by two address bytes, high byte first, which are driven on dio_addr.
- R5: For a write, four further bytes are fetched and packed most significant byte first into dio_wdata, with dio_we high. dio_req, dio_we, dio_addr and dio_wdata stay stable until dio_ack.
- R6: For a read, dio_we is low and no data bytes are fetched. After dio_ack, the 32-bit dio_rdata is written to the channel as four bytes, most significant byte first.
- R7: After each operation that is not the last, a status byte {4'b0000, dio_st, 2'b00} is written to the channel. For a read it follows the four data bytes.
- R8: After the last operation, no status byte is written. The list ends with a single one-cycle done pulse, in the same cycle that busy falls.
- R9: If dio_ack has not arrived within ACK_TIMEOUT cycles of dio_req rising, dio_req drops and rate_err is set. The list then ends with a done pulse. rate_err stays high until the next start.
- R10: ch_req and dio_req are never high together, and a start pulse while busy has no effect on the list in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking a new list |
| busy | output | 1 | A list is in progress |
| done | output | 1 | One-cycle pulse at the end of a list |
| rate_err | output | 1 | Sticky acknowledge-timeout flag, cleared by start |
| ch_req | output | 1 | Byte request to the channel |
| ch_wr | output | 1 | High: store ch_wdata; low: fetch into ch_rdata |
| ch_wdata | output | 8 | Byte to store |
| ch_rdata | input | 8 | Fetched byte, valid with ch_ack |
| ch_ack | input | 1 | Channel completes the current byte request |
| dio_req | output | 1 | Word bus request |
| dio_we | output | 1 | High for write, low for read |
| dio_addr | output | 16 | Word bus address |
| dio_wdata | output | 32 | Write data |
| dio_rdata | input | 32 | Read data, valid with dio_ack |
| dio_st | input | 2 | Device condition bits, valid with dio_ack |
| dio_ack | input | 1 | Device completes the request |

## Verification
The bench builds the bridge with ACK_TIMEOUT set to 16 instead of the default 1024. Device answers that take a few cycles then stay well inside the window, while a device that never answers reaches the abort path within a short run. Both the timeout flag and the carry of status from an aborted list into the next list's header are exercised. The byte and word widths stay at their defaults, so the MSB-first packing, the two-byte address and the status bit positions are checked as the requirements state them.

// File: rtl/byte_dio_bridge.sv
module byte_dio_bridge #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int ACK_TIMEOUT = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              rate_err,
  output logic              ch_req,
  output logic              ch_wr,
  output logic [7:0]        ch_wdata,
  input  logic [7:0]        ch_rdata,
  input  logic              ch_ack,
  output logic              dio_req,
  output logic              dio_we,
  output logic [ADDR_W-1:0] dio_addr,
  output logic [DATA_W-1:0] dio_wdata,
  input  logic [DATA_W-1:0] dio_rdata,
  input  logic [1:0]        dio_st,
  input  logic              dio_ack
);
  localparam int NA   = ADDR_W / 8;
  localparam int NB   = DATA_W / 8;
  localparam int NMAX = (NA > NB) ? NA : NB;
  localparam int CW   = $clog2(NMAX) + 1;
  localparam int TW   = $clog2(ACK_TIMEOUT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ORDER, S_HDR, S_CTL, S_ADR, S_WD, S_BUS, S_RD, S_OPST
  } state_t;

  state_t            state;
  logic [CW-1:0]     cnt;
  logic [TW-1:0]     tmo;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        st_q;
  logic              is_rd, is_last, done_q, err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      tmo     <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      st_q    <= 2'b00;
      is_rd   <= 1'b0;
      is_last <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          err_q <= 1'b0;
          state <= S_ORDER;
        end
        S_ORDER: if (ch_ack) state <= S_HDR;
        S_HDR:   if (ch_ack) state <= S_CTL;
        S_CTL: if (ch_ack) begin
          is_rd   <= ch_rdata[0];
          is_last <= ch_rdata[7];
          cnt     <= '0;
          state   <= S_ADR;
        end
        S_ADR: if (ch_ack) begin
          addr_q <= {addr_q[ADDR_W-9:0], ch_rdata};
          cnt    <= cnt + 1'b1;
          if (cnt == CW'(NA - 1)) begin
            cnt   <= '0;
            tmo   <= '0;
            state <= is_rd ? S_BUS : S_WD;
          end
        end
        S_WD: if (ch_ack) begin
          data_q <= {data_q[DATA_W-9:0], ch_rdata};
          cnt    <= cnt + 1'b1;
          if (cnt == CW'(NB - 1)) begin
            cnt   <= '0;
            tmo   <= '0;
            state <= S_BUS;
          end
        end
        S_BUS: begin
          if (dio_ack) begin
            st_q <= dio_st;
            cnt  <= '0;
            if (is_rd) begin
              data_q <= dio_rdata;
              state  <= S_RD;
            end else if (is_last) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              state <= S_OPST;
            end
          end else if (tmo == TW'(ACK_TIMEOUT - 1)) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        S_RD: if (ch_ack) begin
          data_q <= {data_q[DATA_W-9:0], 8'h00};
          cnt    <= cnt + 1'b1;
          if (cnt == CW'(NB - 1)) begin
            if (is_last) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              state <= S_OPST;
            end
          end
        end
        S_OPST: if (ch_ack) state <= S_CTL;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign rate_err  = err_q;
  assign ch_req    = state inside {S_ORDER, S_HDR, S_CTL, S_ADR, S_WD, S_RD, S_OPST};
  assign ch_wr     = state inside {S_HDR, S_RD, S_OPST};
  assign ch_wdata  = (state == S_RD) ? data_q[DATA_W-1 -: 8] : {4'b0000, st_q, 2'b00};
  assign dio_req   = (state == S_BUS);
  assign dio_we    = !is_rd;
  assign dio_addr  = addr_q;
  assign dio_wdata = data_q;
endmodule

// File: rtl/byte_dio_bridge_chk.sv
module byte_dio_bridge_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              rate_err,
  input logic              ch_req,
  input logic              dio_req,
  input logic              dio_we,
  input logic [ADDR_W-1:0] dio_addr,
  input logic [DATA_W-1:0] dio_wdata,
  input logic              dio_ack
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(ch_req && dio_req)); // R10
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!ch_req && !dio_req)); // R1
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dio_req && !dio_ack) |=> ((dio_req && $stable(dio_addr) && $stable(dio_wdata) && $stable(dio_we)) || $rose(rate_err))); // R5
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n) $rose(rate_err) |-> (!busy && done)); // R9
  AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R8
endmodule

bind byte_dio_bridge byte_dio_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rate_err(rate_err),
  .ch_req(ch_req), .dio_req(dio_req), .dio_we(dio_we), .dio_addr(dio_addr),
  .dio_wdata(dio_wdata), .dio_ack(dio_ack)
);

// File: tb/byte_dio_bridge_tb_top.sv
module byte_dio_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, rate_err, ch_req, ch_wr, dio_req, dio_we;
  logic [7:0]  ch_wdata;
  logic [7:0]  ch_rdata = 8'h00;
  logic        ch_ack = 1'b0;
  logic [15:0] dio_addr;
  logic [31:0] dio_wdata;
  logic [31:0] dio_rdata = '0;
  logic [1:0]  dio_st = 2'b00;
  logic        dio_ack = 1'b0;

  always #2.5 clk = ~clk;

  byte_dio_bridge #(.ACK_TIMEOUT(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .rate_err(rate_err),
    .ch_req(ch_req), .ch_wr(ch_wr), .ch_wdata(ch_wdata), .ch_rdata(ch_rdata), .ch_ack(ch_ack),
    .dio_req(dio_req), .dio_we(dio_we), .dio_addr(dio_addr), .dio_wdata(dio_wdata),
    .dio_rdata(dio_rdata), .dio_st(dio_st), .dio_ack(dio_ack)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0]  list_mem [256];
  logic [7:0]  wr_log [256];
  int rp, wn, cdly;
  logic [15:0] dv_addr [32];
  logic        dv_we [32];
  logic [31:0] dv_wd [32], dv_rd [32];
  logic [1:0]  dv_st [32];
  int dn, ddly, hang_at;
  int done_cnt = 0;
  logic [1:0]  prev_st = 2'b00;
  logic        op_rd [32];
  logic [15:0] op_addr [32];
  logic [31:0] op_wd [32];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      ch_ack = 1'b0; rp = 0; wn = 0; cdly = 0;
    end else if (ch_ack) begin
      ch_ack = 1'b0;
    end else if (ch_req) begin
      if (cdly > 0) cdly--;
      else begin
        ch_ack = 1'b1;
        if (ch_wr) begin wr_log[wn] = ch_wdata; wn++; end
        else begin ch_rdata = list_mem[rp]; rp++; end
        cdly = $urandom % 3;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      dio_ack = 1'b0; dn = 0; ddly = 0;
    end else if (dio_ack) begin
      dio_ack = 1'b0;
    end else if (dio_req && dn != hang_at) begin
      if (ddly > 0) ddly--;
      else begin
        dio_ack = 1'b1;
        dio_rdata = $urandom;
        dio_st = 2'($urandom);
        dv_addr[dn] = dio_addr; dv_we[dn] = dio_we; dv_wd[dn] = dio_wdata;
        dv_rd[dn] = dio_rdata; dv_st[dn] = dio_st;
        dn++;
        ddly = $urandom % 6;
      end
    end
  end

  always @(negedge clk) if (rst_n && done) done_cnt++;

  task automatic run_list(input int nops, input int hang, input bit midstart);
    int p, d0, cyc, ne, nfin;
    logic [7:0] exp [256];
    p = 0;
    list_mem[p++] = 8'h81;
    for (int i = 0; i < nops; i++) begin
      list_mem[p++] = {(i == nops - 1), 6'($urandom), op_rd[i]};
      list_mem[p++] = op_addr[i][15:8];
      list_mem[p++] = op_addr[i][7:0];
      if (!op_rd[i]) for (int b = 3; b >= 0; b--) list_mem[p++] = op_wd[i][8*b +: 8];
    end
    hang_at = hang;
    d0 = done_cnt;
    @(negedge clk);
    rp = 0; wn = 0; dn = 0;
    start = 1'b1;
    cyc = 0;
    while (done_cnt == d0 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      start = (midstart && cyc == 8);
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(done_cnt == d0 + 1, "R8 single done pulse per list", done_cnt - d0, 1);
    chk(busy == 1'b0, "R8 idle after list", busy, 0);
    chk(rate_err == (hang >= 0), "R9 rate_err flag", rate_err, hang >= 0);
    nfin = (hang >= 0) ? hang : nops;
    chk(dn == nfin, "R4 bus transaction count", dn, nfin);
    for (int i = 0; i < nfin && i < dn; i++) begin
      chk(dv_addr[i] == op_addr[i], "R4 address high byte first", dv_addr[i], op_addr[i]);
      chk(dv_we[i] == !op_rd[i], "R4 read/write select", dv_we[i], !op_rd[i]);
      if (!op_rd[i]) chk(dv_wd[i] == op_wd[i], "R5 write word MSB first", dv_wd[i], op_wd[i]);
    end
    if (hang < 0) chk(rp == p, "R2 order byte consumed, whole list fetched", rp, p);
    ne = 0;
    exp[ne++] = {4'b0000, prev_st, 2'b00};
    for (int i = 0; i < nfin; i++) begin
      if (op_rd[i]) for (int b = 3; b >= 0; b--) exp[ne++] = dv_rd[i][8*b +: 8];
      if (i != nops - 1) exp[ne++] = {4'b0000, dv_st[i], 2'b00};
    end
    chk(wn == ne, "R7 stored byte count", wn, ne);
    for (int k = 0; k < ne && k < wn; k++)
      chk(wr_log[k] == exp[k], (k == 0) ? "R3 header status byte" : "R6 R7 stored byte", wr_log[k], exp[k]);
    if (nfin > 0) prev_st = dv_st[nfin - 1];
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    hang_at = -1;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && rate_err == 0, "R1 reset outputs", {busy, done, rate_err}, 0);
    chk(ch_req == 0 && dio_req == 0, "R1 reset requests", {ch_req, dio_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ch_req == 0 && dio_req == 0, "R1 idle quiet", {ch_req, dio_req}, 0);

    op_rd[0] = 0; op_addr[0] = 16'hFFFF; op_wd[0] = 32'hFFFF_FFFF;
    run_list(1, -1, 0);
    op_rd[0] = 1; op_addr[0] = 16'h0000;
    run_list(1, -1, 0);
    op_rd[0] = 1; op_addr[0] = 16'h1234;
    op_rd[1] = 0; op_addr[1] = 16'hA55A; op_wd[1] = 32'h0102_0304;
    op_rd[2] = 1; op_addr[2] = 16'h8001;
    run_list(3, -1, 1);
    op_rd[0] = 0; op_addr[0] = 16'h0F0F; op_wd[0] = 32'hDEAD_BEEF;
    op_rd[1] = 1; op_addr[1] = 16'h4242;
    op_rd[2] = 0; op_addr[2] = 16'h7777; op_wd[2] = 32'h0;
    run_list(3, 1, 0);
    op_rd[0] = 1; op_addr[0] = 16'h0001;
    run_list(1, 0, 0);
    run_list(1, -1, 0);
    chk(rate_err == 0, "R9 rate_err cleared by start", rate_err, 0);

    for (int t = 0; t < 25; t++) begin
      int n;
      n = 1 + $urandom % 6;
      for (int i = 0; i < n; i++) begin
        op_rd[i] = 1'($urandom); op_addr[i] = 16'($urandom); op_wd[i] = $urandom;
      end
      run_list(n, -1, (t % 5 == 2) && n >= 2);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule